// File: doc/BRIEF.md
# Multiplier-Free CIC Decimation Filter

This block lowers the sample rate of a signed data stream by an integer factor using a cascaded integrator-comb structure. It uses only adders, subtractors and registers. A chain of integrators accumulates every accepted input sample. A phase counter then keeps one integrator result in every RATE samples. A chain of comb (differencing) sections runs on the kept samples only, and each comb subtracts the value it saw DLY kept samples earlier. DLY may be 1 or 2. The number of sections, the rate change and the differential delay are parameters.

The internal width grows with the filter gain, so no overflow is ever visible at the output. The integrators wrap in two's complement, and the combs cancel that wrap exactly. Every section is registered, which keeps the adder depth at one carry chain per clock. The result leaves at full precision with a strobe that lasts one cycle. There is no rounding, no gain correction and no flow control.

Top module: `cic_decimator`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `out_valid` is 0 and `out_data` is 0. Reset clears all integrator, comb and phase state, so the first output after reset belongs to the RATE-th accepted input after reset.
- R2: Only cycles with `in_valid` high advance the filter. Idle cycles placed between inputs leave the output sequence unchanged.
- R3: `out_valid` pulses for one cycle per RATE accepted inputs. The number of pulses never exceeds the number of accepted inputs divided by RATE. `out_data` holds its value between pulses.
- R4: Output j (counting from 0) equals the sum over i of h[i]·x[(j+1)·RATE−1−i]. Here x is the accepted input sequence, with x = 0 before reset, and h holds the coefficients of (1 + z⁻¹ + … + z^−(RATE·DLY−1)) raised to the power N_STG. The output is a two's complement value OUT_W bits wide.
- R5: A constant input c settles to c·(RATE·DLY)^N_STG once the first N_STG·(RATE·DLY−1) inputs have passed.
- R6: The most negative and the most positive constant inputs give their exact scaled results with no overflow. With the defaults these are −128 → −65536 and 127 → 65024.
- R7: DLY = 2 is supported and gives the response of R4 and R5 with RATE·DLY = 2·RATE.
- R8: `out_valid` rises 2·N_STG clock edges after the edge that accepts the RATE-th input of a group.
- R9: OUT_W = IN_W + N_STG·ceil(log2(RATE·DLY)). This is 17 with the defaults (IN_W=8, N_STG=3, RATE=8, DLY=1) and 20 with DLY=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for each decimated output |
| out_data | output | OUT_W | Signed full-precision output sample |

## Verification
The input patterns are:
- An impulse, which reproduces the decimated coefficient set and exposes any error in the order of the sections or the comb delay.
- The two extreme constants, which show the DC gain and any width or sign-extension fault.
- A ramp, which checks the higher-order integration.
- An alternating-sign stream with idle gaps and a pseudo-random stream with gaps, which separate correct valid gating from integrators that run on every clock.

The same stimulus drives a DLY=1 and a DLY=2 instance, so an ignored delay setting shows as a mismatch. Directed tests cover the reset value, a reset in the middle of a group, which must restart the phase, and the output latency.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // bits added across all sections for a given rate change and delay
    function automatic int cic_growth(input int n_stg, input int rate, input int dly);
        return n_stg * $clog2(rate * dly);
    endfunction

    function automatic int cic_acc_width(input int in_w, input int n_stg,
                                         input int rate, input int dly);
        return in_w + cic_growth(n_stg, rate, dly);
    endfunction

    // width of the decimation phase counter
    function automatic int cic_phase_width(input int rate);
        return (rate > 1) ? $clog2(rate) : 1;
    endfunction

endpackage

// File: rtl/cic_integrator.sv
module cic_integrator #(
    parameter int W = 17
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                i_vld,
    input  logic signed [W-1:0] i_dat,
    output logic                o_vld,
    output logic signed [W-1:0] o_dat
);
    logic signed [W-1:0] acc_q;

    // wrap-around accumulation, advanced on accepted samples only
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            o_vld <= 1'b0;
        end else begin
            o_vld <= i_vld;
            if (i_vld) begin
                acc_q <= acc_q + i_dat;
            end
        end
    end

    assign o_dat = acc_q;
endmodule

// File: rtl/cic_rate_gate.sv
module cic_rate_gate #(
    parameter int W    = 17,
    parameter int RATE = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                i_vld,
    input  logic signed [W-1:0] i_dat,
    output logic                o_vld,
    output logic signed [W-1:0] o_dat
);
    import cic_pkg::*;

    localparam int PW = cic_phase_width(RATE);
    localparam logic [PW-1:0] LAST = PW'(RATE - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            o_vld   <= 1'b0;
            o_dat   <= '0;
        end else begin
            o_vld <= 1'b0;
            if (i_vld) begin
                if (phase_q == LAST) begin
                    phase_q <= '0;
                    o_vld   <= 1'b1;
                    o_dat   <= i_dat;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
    parameter int W   = 17,
    parameter int DLY = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                i_vld,
    input  logic signed [W-1:0] i_dat,
    output logic                o_vld,
    output logic signed [W-1:0] o_dat
);
    // history of the last DLY decimated samples, newest first
    logic signed [W-1:0] hist_q [DLY];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DLY; k++) begin
                hist_q[k] <= '0;
            end
            o_vld <= 1'b0;
            o_dat <= '0;
        end else begin
            o_vld <= i_vld;
            if (i_vld) begin
                o_dat     <= i_dat - hist_q[DLY-1];
                hist_q[0] <= i_dat;
                for (int k = 1; k < DLY; k++) begin
                    hist_q[k] <= hist_q[k-1];
                end
            end
        end
    end
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator #(
    parameter  int IN_W  = 8,
    parameter  int N_STG = 3,
    parameter  int RATE  = 8,
    parameter  int DLY   = 1,
    localparam int ACC_W = cic_pkg::cic_acc_width(IN_W, N_STG, RATE, DLY)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_data
);
    logic                    ivld [N_STG+1];
    logic signed [ACC_W-1:0] idat [N_STG+1];
    logic                    cvld [N_STG+1];
    logic signed [ACC_W-1:0] cdat [N_STG+1];

    assign ivld[0] = in_valid;
    assign idat[0] = {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data};

    for (genvar s = 0; s < N_STG; s++) begin : g_integ
        cic_integrator #(.W(ACC_W)) u_integ (
            .clk   (clk),
            .rst   (rst),
            .i_vld (ivld[s]),
            .i_dat (idat[s]),
            .o_vld (ivld[s+1]),
            .o_dat (idat[s+1])
        );
    end

    cic_rate_gate #(.W(ACC_W), .RATE(RATE)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .i_vld (ivld[N_STG]),
        .i_dat (idat[N_STG]),
        .o_vld (cvld[0]),
        .o_dat (cdat[0])
    );

    for (genvar s = 0; s < N_STG; s++) begin : g_comb
        cic_comb #(.W(ACC_W), .DLY(DLY)) u_comb (
            .clk   (clk),
            .rst   (rst),
            .i_vld (cvld[s]),
            .i_dat (cdat[s]),
            .o_vld (cvld[s+1]),
            .o_dat (cdat[s+1])
        );
    end

    assign out_valid = cvld[N_STG];
    assign out_data  = cdat[N_STG];
endmodule

// File: rtl/cic_decimator_chk.sv
module cic_decimator_chk #(
    parameter int RATE  = 8,
    parameter int OUT_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);
    logic [31:0] n_in_q;
    logic [31:0] n_out_q;
    logic [63:0] needed;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_in_q  <= '0;
            n_out_q <= '0;
        end else begin
            if (in_valid)  n_in_q  <= n_in_q + 32'd1;
            if (out_valid) n_out_q <= n_out_q + 32'd1;
        end
    end

    assign needed = (64'(n_out_q) + 64'd1) * 64'(RATE);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0)); // R1
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R3
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data)); // R3
    AST_PACE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (needed <= 64'(n_in_q))); // R3
endmodule

bind cic_decimator cic_decimator_chk #(.RATE(RATE), .OUT_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/cic_decimator_tb.sv
`timescale 1ns/1ps
module cic_decimator_tb;
    localparam int IN_W = 8;
    localparam int N    = 3;
    localparam int R    = 8;
    localparam int W1   = 17;
    localparam int W2   = 20;
    localparam int NIN  = 64;
    localparam int HMAX = 64;
    localparam int NPAT = 6;
    // pattern table: kind 0 impulse, 1 constant, 2 ramp, 3 alternating, 4 pseudo-random
    localparam int P_KIND [NPAT] = '{0, 1, 1, 2, 3, 4};
    localparam int P_AMP  [NPAT] = '{100, 127, -128, 7, 90, 0};
    localparam int P_GAP  [NPAT] = '{0, 0, 0, 0, 2, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [IN_W-1:0] in_data = '0;
    logic          o1_vld, o2_vld;
    logic [W1-1:0] o1_dat;
    logic [W2-1:0] o2_dat;

    always #2.5 clk = ~clk;

    cic_decimator #(.IN_W(IN_W), .N_STG(N), .RATE(R), .DLY(1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(o1_vld), .out_data(o1_dat));
    cic_decimator #(.IN_W(IN_W), .N_STG(N), .RATE(R), .DLY(2)) u_dut_m2 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(o2_vld), .out_data(o2_dat));

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int xs [NIN];
    longint h1 [HMAX];
    longint h2 [HMAX];
    logic [W1-1:0] g1 [16];
    logic [W2-1:0] g2 [16];
    int gi1 = 0, gi2 = 0, first1 = -1, hold_bad = 0;
    logic [W1-1:0] last1 = '0;
    logic [W2-1:0] last2 = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (o1_vld) begin
                if (gi1 < 16) g1[gi1] = o1_dat;
                if (first1 < 0) first1 = cyc;
                gi1++;
            end else if (o1_dat != last1) hold_bad++;
            if (o2_vld) begin
                if (gi2 < 16) g2[gi2] = o2_dat;
                gi2++;
            end else if (o2_dat != last2) hold_bad++;
        end
        last1 = o1_dat;
        last2 = o2_dat;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // coefficients of the N-th power of a length R*m box
    task automatic build_h(input int m);
        longint a [HMAX];
        longint b [HMAX];
        int len = 1;
        for (int k = 0; k < HMAX; k++) a[k] = (k == 0) ? 1 : 0;
        for (int s = 0; s < N; s++) begin
            for (int k = 0; k < HMAX; k++) begin
                b[k] = 0;
                for (int d = 0; d < R*m; d++) if (k - d >= 0) b[k] += a[k-d];
            end
            len += R*m - 1;
            for (int k = 0; k < HMAX; k++) a[k] = b[k];
        end
        for (int k = 0; k < HMAX; k++) begin
            if (m == 1) h1[k] = a[k]; else h2[k] = a[k];
        end
    endtask

    function automatic longint exp_y(input int m, input int j);
        longint s = 0;
        int n = (j + 1) * R - 1;
        int len = N * (R*m - 1) + 1;
        for (int i = 0; i < len; i++)
            if (n - i >= 0) s += ((m == 1) ? h1[i] : h2[i]) * longint'(xs[n-i]);
        return s;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(o1_vld == 1'b0 && o2_vld == 1'b0, "R1 valid low in reset", o1_vld, 0);
        chk(o1_dat == '0 && o2_dat == '0, "R1 data zero in reset", longint'($signed(o1_dat)), 0);
        rst = 1'b0;
        gi1 = 0; gi2 = 0; first1 = -1;
    endtask

    task automatic feed(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = IN_W'(xs[i]);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic fill(input int kind, input int amp);
        int st = 12345;
        for (int i = 0; i < NIN; i++) begin
            case (kind)
                0: xs[i] = (i == 0) ? amp : 0;
                1: xs[i] = amp;
                2: xs[i] = ((i * amp) % 256) - 128;
                3: xs[i] = (i % 2 == 0) ? amp : -amp;
                default: begin
                    st = (st * 1103515245 + 12345) & 32'h7fffffff;
                    xs[i] = ((st >>> 16) & 255) - 128;
                end
            endcase
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        build_h(1);
        build_h(2);
        chk($bits(o1_dat) == 17, "R9 width DLY1", $bits(o1_dat), 17);
        chk($bits(o2_dat) == 20, "R9 width DLY2", $bits(o2_dat), 20);
        do_reset();
        @(negedge clk);
        chk(o1_vld == 1'b0 && o1_dat == '0, "R1 state after release", longint'($signed(o1_dat)), 0);

        // table walk: R4 impulse/ramp, R5/R6 constants, R2 gapped streams, R7 delay of 2
        for (int p = 0; p < NPAT; p++) begin
            fill(P_KIND[p], P_AMP[p]);
            do_reset();
            feed(NIN, P_GAP[p]);
            repeat (4 * N + 4) @(negedge clk);
            chk(gi1 == NIN / R, "R3 pulse count DLY1", gi1, NIN / R);
            chk(gi2 == NIN / R, "R3 pulse count DLY2", gi2, NIN / R);
            for (int j = 0; j < NIN / R; j++) begin
                chk(g1[j] == W1'(exp_y(1, j)), (P_GAP[p] > 0) ? "R2 gapped DLY1" : "R4 response DLY1",
                    longint'($signed(g1[j])), exp_y(1, j));
                chk(g2[j] == W2'(exp_y(2, j)), "R7 response DLY2",
                    longint'($signed(g2[j])), exp_y(2, j));
            end
            if (P_KIND[p] == 1) begin
                chk(longint'($signed(g1[NIN/R-1])) == longint'(P_AMP[p]) * 512,
                    "R5 R6 DC gain DLY1", longint'($signed(g1[NIN/R-1])), longint'(P_AMP[p]) * 512);
                chk(longint'($signed(g2[NIN/R-1])) == longint'(P_AMP[p]) * 4096,
                    "R5 R7 DC gain DLY2", longint'($signed(g2[NIN/R-1])), longint'(P_AMP[p]) * 4096);
            end
        end
        chk(hold_bad == 0, "R3 data held between pulses", hold_bad, 0);

        // latency from the accepting edge of the R-th input
        begin
            int k;
            fill(1, 5);
            do_reset();
            for (int i = 0; i < R; i++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = 8'sd5;
            end
            @(posedge clk);
            #1 k = cyc;
            @(negedge clk);
            in_valid = 1'b0;
            repeat (4 * N) @(negedge clk);
            chk(first1 - k == 2 * N, "R8 latency", first1 - k, 2 * N);
        end

        // reset in the middle of a group restarts the phase and clears state
        fill(1, 50);
        do_reset();
        feed(13, 0);
        fill(1, 7);
        do_reset();
        feed(R, 0);
        repeat (4 * N) @(negedge clk);
        chk(gi1 == 1, "R1 one output after mid reset", gi1, 1);
        chk(g1[0] == W1'(exp_y(1, 0)), "R1 cleared state", longint'($signed(g1[0])), exp_y(1, 0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule